// File: doc/BRIEF.md
# Dual-Channel Converter Result and Offset Register Slice

This block is the register slice that sits between two sigma-delta converter channels (a primary and an auxiliary) and a simple synchronous register bus. For each channel it keeps the latest 24-bit conversion result with a ready flag, and a 16-bit offset coefficient. The converter side delivers results with a one-cycle valid strobe and finished calibrations with a one-cycle done strobe. Software reads results, the flags and the coefficients, and may overwrite a coefficient.

A channel's result register is frozen while its ready flag is up, so software always reads the sample that raised the flag. Reading the primary result drops both flags; reading the auxiliary result drops only its own. Software writes to a coefficient are accepted only once the converter has been enabled and idle for a fixed dwell (23 us, counted in clock cycles from the clock rate parameter). A finished calibration always overwrites its coefficient.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both results read as zero, the status word reads zero, and the primary and auxiliary coefficients read PRI_OF_INIT and AUX_OF_INIT.
- R2: A result-valid strobe on a channel whose ready flag is clear latches the data and sets the flag at the same edge; the status word at offset 0x52C returns the primary flag in bit 0 and the auxiliary flag in bit 1, other bits zero.
- R3: While a channel's ready flag is set, further result strobes on that channel leave its result register unchanged.
- R4: A read of the primary result (offset 0x51C) returns that result and clears both ready flags.
- R5: A read of the auxiliary result (offset 0x520) returns that result and clears only the auxiliary flag.
- R6: When a flag clear by a read and a result strobe on a channel with a clear flag fall in the same cycle, the flag ends set and the new data is latched.
- R7: The primary coefficient (offset 0x524) and auxiliary coefficient (offset 0x528) read back over the bus; a write to one takes effect only if enable and idle have both been high for CLK_MHZ*DWELL_US consecutive cycles before the write edge, and the count restarts whenever either drops.
- R8: Coefficient writes outside that condition are dropped, and writes to the result or status offsets change nothing.
- R9: A calibration-done strobe overwrites its channel's coefficient whether or not writes are open, and wins over a software write to the same coefficient in the same cycle.
- R10: Read data appears in the cycle after the read strobe is sampled; it is zero for unmapped offsets and in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | COEF_W | Write data (only coefficients are writable) |
| bus_rdata | output | RD_W | Registered read data |
| pri_res_vld | input | 1 | Primary result valid |
| pri_res_data | input | RES_W | Primary result |
| aux_res_vld | input | 1 | Auxiliary result valid |
| aux_res_data | input | RES_W | Auxiliary result |
| pri_cal_done | input | 1 | Primary offset calibration finished |
| pri_cal_coef | input | COEF_W | Primary calibration coefficient |
| aux_cal_done | input | 1 | Auxiliary offset calibration finished |
| aux_cal_coef | input | COEF_W | Auxiliary calibration coefficient |
| adc_en | input | 1 | Converter enabled |
| adc_idle | input | 1 | Converter in idle mode |

## Verification
Results are driven one channel at a time, on both channels with staggered flags, and as repeat strobes on a channel whose flag is still up, which separates a correct lock from a register that simply follows the latest sample. Reads of each result offset with both flags set tell a both-flags clear from a per-channel one, and a read coinciding with a fresh strobe shows the set-over-clear order. Coefficient writes are placed one cycle before and exactly at the end of the dwell, right after a short idle drop, after disabling, and together with a calibration strobe, so an off-by-one or a missing counter restart shows up as a wrong coefficient.

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int ADDR_W   = 12,
  parameter int RES_W    = 24,
  parameter int COEF_W   = 16,
  parameter int RD_W     = 32,
  parameter int CLK_MHZ  = 200,
  parameter int DWELL_US = 23,
  parameter logic [COEF_W-1:0] PRI_OF_INIT = 16'h8000,
  parameter logic [COEF_W-1:0] AUX_OF_INIT = 16'h7FF0,
  parameter logic [ADDR_W-1:0] A_PRI_RES = 12'h51C,
  parameter logic [ADDR_W-1:0] A_AUX_RES = 12'h520,
  parameter logic [ADDR_W-1:0] A_PRI_OF  = 12'h524,
  parameter logic [ADDR_W-1:0] A_AUX_OF  = 12'h528,
  parameter logic [ADDR_W-1:0] A_STAT    = 12'h52C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [COEF_W-1:0] bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic              pri_res_vld,
  input  logic [RES_W-1:0]  pri_res_data,
  input  logic              aux_res_vld,
  input  logic [RES_W-1:0]  aux_res_data,
  input  logic              pri_cal_done,
  input  logic [COEF_W-1:0] pri_cal_coef,
  input  logic              aux_cal_done,
  input  logic [COEF_W-1:0] aux_cal_coef,
  input  logic              adc_en,
  input  logic              adc_idle
);

  localparam int DWELL_CYC = CLK_MHZ * DWELL_US;
  localparam int CNT_W     = $clog2(DWELL_CYC + 1);

  logic [RES_W-1:0]  pri_res, aux_res;
  logic [COEF_W-1:0] pri_of, aux_of;
  logic [1:0]        rdy, set_f, clr_f;
  logic [CNT_W-1:0]  dwell;
  logic              gate_open, rd_pri, rd_aux, wr_pri, wr_aux;
  logic [RD_W-1:0]   rd_mux;

  assign rd_pri = bus_rd && (bus_addr == A_PRI_RES);
  assign rd_aux = bus_rd && (bus_addr == A_AUX_RES);
  assign set_f  = {aux_res_vld & ~rdy[1], pri_res_vld & ~rdy[0]};
  assign clr_f  = {rd_pri | rd_aux, rd_pri};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy     <= '0;
      pri_res <= '0;
      aux_res <= '0;
    end else begin
      rdy <= (rdy & ~clr_f) | set_f;
      if (set_f[0]) pri_res <= pri_res_data;
      if (set_f[1]) aux_res <= aux_res_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !(adc_en && adc_idle))
      dwell <= '0;
    else if (dwell != CNT_W'(DWELL_CYC))
      dwell <= dwell + 1'b1;
  end

  assign gate_open = adc_en && adc_idle && (dwell == CNT_W'(DWELL_CYC));
  assign wr_pri    = bus_wr && gate_open && (bus_addr == A_PRI_OF);
  assign wr_aux    = bus_wr && gate_open && (bus_addr == A_AUX_OF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_of <= PRI_OF_INIT;
      aux_of <= AUX_OF_INIT;
    end else begin
      if (pri_cal_done)  pri_of <= pri_cal_coef;
      else if (wr_pri)   pri_of <= bus_wdata;
      if (aux_cal_done)  aux_of <= aux_cal_coef;
      else if (wr_aux)   aux_of <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_PRI_RES: rd_mux = RD_W'(pri_res);
      A_AUX_RES: rd_mux = RD_W'(aux_res);
      A_PRI_OF:  rd_mux = RD_W'(pri_of);
      A_AUX_OF:  rd_mux = RD_W'(aux_of);
      A_STAT:    rd_mux = RD_W'(rdy);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

endmodule

module adc_result_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int RES_W  = 24,
  parameter int COEF_W = 16,
  parameter int RD_W   = 32,
  parameter logic [ADDR_W-1:0] A_PRI_RES = 12'h51C,
  parameter logic [ADDR_W-1:0] A_AUX_RES = 12'h520,
  parameter logic [ADDR_W-1:0] A_PRI_OF  = 12'h524
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [RD_W-1:0]   bus_rdata,
  input logic              pri_res_vld,
  input logic [RES_W-1:0]  pri_res_data,
  input logic              aux_res_vld,
  input logic              pri_cal_done,
  input logic [COEF_W-1:0] pri_cal_coef,
  input logic              adc_en,
  input logic              adc_idle,
  input logic [1:0]        rdy,
  input logic [RES_W-1:0]  pri_res,
  input logic [RES_W-1:0]  aux_res,
  input logic [COEF_W-1:0] pri_of
);

  // R2
  pri_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_res_vld && !rdy[0]) |=> (rdy[0] && pri_res == $past(pri_res_data)));

  // R3
  pri_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy[0] |=> $stable(pri_res));

  // R3
  aux_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy[1] && aux_res_vld) |=> $stable(aux_res));

  // R4
  pri_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_PRI_RES && !pri_res_vld && !aux_res_vld) |=> (rdy == 2'b00));

  // R5
  aux_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_AUX_RES && rdy[0]) |=> rdy[0]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_PRI_RES && pri_res_vld && !rdy[0]) |=> rdy[0]);

  // R8
  closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PRI_OF && !pri_cal_done && !(adc_en && adc_idle)) |=> $stable(pri_of));

  // R9
  cal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_cal_done |=> (pri_of == $past(pri_cal_coef)));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind adc_result_regs adc_result_regs_chk #(
  .ADDR_W(ADDR_W), .RES_W(RES_W), .COEF_W(COEF_W), .RD_W(RD_W),
  .A_PRI_RES(A_PRI_RES), .A_AUX_RES(A_AUX_RES), .A_PRI_OF(A_PRI_OF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .pri_res_vld(pri_res_vld), .pri_res_data(pri_res_data),
  .aux_res_vld(aux_res_vld), .pri_cal_done(pri_cal_done), .pri_cal_coef(pri_cal_coef),
  .adc_en(adc_en), .adc_idle(adc_idle), .rdy(rdy), .pri_res(pri_res),
  .aux_res(aux_res), .pri_of(pri_of)
);

// File: tb/sim_adc_result_regs.sv
`timescale 1ns/1ps
module sim_adc_result_regs;
  localparam int DW = 200 * 23;
  localparam logic [11:0] PR = 12'h51C, AR = 12'h520, PO = 12'h524, AO = 12'h528, ST = 12'h52C;

  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pri_res_vld = 0, aux_res_vld = 0;
  logic [23:0] pri_res_data = '0, aux_res_data = '0;
  logic        pri_cal_done = 0, aux_cal_done = 0;
  logic [15:0] pri_cal_coef = '0, aux_cal_coef = '0;
  logic        adc_en = 0, adc_idle = 0;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #2.5 clk = ~clk;

  adc_result_regs u0 (.*);

  always @(posedge clk) rd_seen <= bus_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read got=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s got=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic res(input bit aux, input logic [23:0] d);
    @(negedge clk);
    if (aux) begin aux_res_vld = 1; aux_res_data = d; end
    else     begin pri_res_vld = 1; pri_res_data = d; end
    @(negedge clk);
    aux_res_vld = 0; pri_res_vld = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (bus_rdata !== 32'h0) begin bad++; $display("FAIL R10 idle rdata got=%h exp=0", bus_rdata); end
    // R1 reset state
    rd(PR, 32'h0, "R1 pri result");
    rd(AR, 32'h0, "R1 aux result");
    rd(ST, 32'h0, "R1 status");
    rd(PO, 32'h8000, "R1 pri coef");
    rd(AO, 32'h7FF0, "R1 aux coef");
    rd(12'h530, 32'h0, "R10 unmapped");
    // R2 / R3 primary latch and lock
    res(0, 24'h123456);
    rd(ST, 32'h1, "R2 status pri");
    res(0, 24'hABCDEF);
    rd(PR, 32'h123456, "R3 pri locked");
    rd(ST, 32'h0, "R4 cleared");
    // R5 aux clear only
    res(1, 24'h00F00F);
    res(1, 24'h111111);
    rd(ST, 32'h2, "R2 status aux");
    res(0, 24'h222222);
    rd(ST, 32'h3, "R2 status both");
    rd(AR, 32'h00F00F, "R3 aux locked");
    rd(ST, 32'h1, "R5 only aux cleared");
    rd(PR, 32'h222222, "R2 pri data");
    rd(ST, 32'h0, "R4 cleared");
    // R4 primary read clears both
    res(0, 24'h333333);
    res(1, 24'h444444);
    rd(PR, 32'h333333, "R4 pri data");
    rd(ST, 32'h0, "R4 both cleared");
    rd(AR, 32'h444444, "R4 aux data kept");
    // R6 set wins over clear
    @(negedge clk);
    bus_addr = PR; bus_rd = 1; pri_res_vld = 1; pri_res_data = 24'h555555;
    exp_q.push_back(32'h333333); tag_q.push_back("R6 old data");
    @(negedge clk);
    bus_rd = 0; pri_res_vld = 0;
    rd(ST, 32'h1, "R6 flag set");
    rd(PR, 32'h555555, "R6 new data");
    // R8 dropped writes
    wr(PO, 16'h1111);
    rd(PO, 32'h8000, "R8 write while disabled");
    wr(PR, 16'hFFFF);
    wr(ST, 16'hFFFF);
    rd(PR, 32'h555555, "R8 write to result");
    rd(ST, 32'h0, "R8 write to status");
    // R7 dwell boundary
    @(negedge clk);
    adc_en = 1; adc_idle = 1;
    repeat (DW - 1) @(negedge clk);
    bus_addr = AO; bus_wdata = 16'h2222; bus_wr = 1;
    @(negedge clk);
    bus_addr = PO; bus_wdata = 16'h3333;
    @(negedge clk);
    bus_wr = 0;
    rd(AO, 32'h7FF0, "R7 one cycle early");
    rd(PO, 32'h3333, "R7 at dwell end");
    // R7 restart after idle drop
    @(negedge clk); adc_idle = 0;
    @(negedge clk); adc_idle = 1;
    wr(AO, 16'h9999);
    rd(AO, 32'h7FF0, "R7 restart");
    // R9 calibration while closed
    @(negedge clk); pri_cal_done = 1; pri_cal_coef = 16'h4444;
    @(negedge clk); pri_cal_done = 0; aux_cal_done = 1; aux_cal_coef = 16'h5555;
    @(negedge clk); aux_cal_done = 0;
    rd(PO, 32'h4444, "R9 pri cal");
    rd(AO, 32'h5555, "R9 aux cal");
    // R9 cal beats write
    repeat (DW + 5) @(negedge clk);
    bus_addr = AO; bus_wdata = 16'h6666; bus_wr = 1; aux_cal_done = 1; aux_cal_coef = 16'h7777;
    @(negedge clk);
    bus_wr = 0; aux_cal_done = 0;
    rd(AO, 32'h7777, "R9 cal over write");
    wr(AO, 16'h6666);
    rd(AO, 32'h6666, "R7 open write");
    @(negedge clk); adc_en = 0;
    wr(PO, 16'hAAAA);
    rd(PO, 32'h4444, "R8 write after disable");
    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin bad++; $display("FAIL R10 pending reads got=%0d exp=0", exp_q.size()); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule